// File: doc/BRIEF.md
# Privilege-Filtered Event Counter

This block is one performance event counter. It is driven by a 32-bit type register. The low sixteen bits of that register pick which line of an event-valid vector is counted. A group of filter bits in the upper half decides, from the current privilege level and security state, whether counting is allowed in a given cycle.

Some filters are plain block bits. Others take effect only when their value differs from a companion bit. One filter uses inverted sense. Both the type register and the count are reached through one small read/write port. The running count is also driven on a dedicated output.

The count advances by one on every clock edge at which three conditions hold: the selected event line is high, the event number is supported, and no filter blocks the current context. The count wraps modulo 2^32.

Top module: `evt_filt_counter`

## Requirements
- R1: After reset, the type register reads 0 and the count is 0. With the type register at 0, counting is allowed at levels 0, 1 and 3 and blocked at level 2.
- R2: The count rises by exactly one at each clock edge where `evt_i[event number]` is 1 and counting is allowed. Lines of `evt_i` other than the selected one have no effect. A change is visible on `cnt_o` one clock after the event is sampled.
- R3: An event number (bits 15:0) at or above NUM_EVT (default 64) never counts. A read of the type register still returns the number exactly as written.
- R4: Type register bits 26:22 and 20:16 always read 0. Writes to those bits are ignored.
- R5: Type bit 31 set blocks counting at level 1. It also blocks counting at level 3 while `el3_narrow_i` is 1. At level 3 with `el3_narrow_i` at 0, the bit has no effect.
- R6: Type bit 30 set blocks counting at level 0.
- R7: At level 1 in non-secure state (`sec_i` = 2'b01), counting is blocked whenever bit 29 differs from bit 31. Bit 29 has no effect in secure (2'b00) or realm (2'b10) state.
- R8: At level 0, counting is blocked in non-secure state when bit 28 differs from bit 30, and in realm state when bit 21 differs from bit 30. Neither bit affects level 1.
- R9: Type bit 27 at 0 blocks counting at level 2. At 1, it has no effect.
- R10: A count write (`reg_addr_i` = 1) in the same cycle as an allowed event loads the written value without an added increment. Counting on from 32'hFFFF_FFFF wraps to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| evt_i | input | NUM_EVT | Event-valid vector, one line per event number |
| lvl_i | input | 2 | Current privilege level, 0 to 3 |
| sec_i | input | 2 | Security state: 00 secure, 01 non-secure, 10 realm, 11 treated as secure |
| el3_narrow_i | input | 1 | Level 3 is running in the 32-bit state |
| wr_en_i | input | 1 | Register write strobe |
| reg_addr_i | input | 1 | Register select: 0 type register, 1 count |
| wr_data_i | input | 32 | Write data |
| rd_data_o | output | 32 | Combinational read data for the selected register |
| cnt_o | output | 32 | Running count |

## Verification
The bench walks each compare-type filter through its matched and mismatched settings, at the level it guards and at a neighbouring level. A design that tested the filter bit alone, or applied it in the wrong security state, would count where it must stop, or stop where it must count.

Reset defaults are checked at level 2, where a missing inversion of the level-2 bit would let counting through. Event number 63 and event number 256 are checked against an all-ones event vector; an index that truncated the event number would count for the unsupported one.

The same-cycle write and increment, and the wrap from all ones, catch a counter that adds after loading or saturates.

// File: rtl/efc_pkg.sv
package efc_pkg;
  typedef enum logic [1:0] {
    SEC_S  = 2'b00,
    SEC_NS = 2'b01,
    SEC_RL = 2'b10,
    SEC_X  = 2'b11
  } sec_e;

  // field placement is fixed by the register layout
  typedef struct packed {
    logic        blk_k;        // 31
    logic        blk_u;        // 30
    logic        ns_k_ref;     // 29
    logic        ns_u_ref;     // 28
    logic        hyp_en;       // 27
    logic [4:0]  rsv_hi;       // 26:22
    logic        realm_u_ref;  // 21
    logic [4:0]  rsv_lo;       // 20:16
    logic [15:0] evt_sel;      // 15:0
  } cfg_t;

  localparam logic [31:0] CFG_RSV_MASK = 32'h07DF_0000;
  localparam logic [31:0] CFG_WR_MASK  = ~CFG_RSV_MASK;
endpackage

// File: rtl/efc_cfg_reg.sv
module efc_cfg_reg
  import efc_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_i,
  input  logic [31:0] wr_data_i,
  output cfg_t        cfg_o
);
  logic [31:0] cfg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   cfg_q <= '0;
    else if (wr_i) cfg_q <= wr_data_i & CFG_WR_MASK;
  end

  assign cfg_o = cfg_t'(cfg_q);

  // R4
  a_r4_rsv_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_o.rsv_hi == 5'd0) && (cfg_o.rsv_lo == 5'd0));
  // R3: event number kept as written
  a_r3_sel_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> cfg_o.evt_sel == $past(wr_data_i[15:0]));
endmodule

// File: rtl/efc_gate.sv
module efc_gate
  import efc_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  cfg_t       cfg_i,
  input  logic [1:0] lvl_i,
  input  logic [1:0] sec_i,
  input  logic       el3_narrow_i,
  output logic       allow_o
);
  logic is_ns, is_rl;
  logic blk_l0, blk_l1, blk_l2, blk_l3;

  assign is_ns = (sec_i == SEC_NS);
  assign is_rl = (sec_i == SEC_RL);

  always_comb begin
    blk_l0 = cfg_i.blk_u
           | (is_ns & (cfg_i.ns_u_ref    ^ cfg_i.blk_u))
           | (is_rl & (cfg_i.realm_u_ref ^ cfg_i.blk_u));
    blk_l1 = cfg_i.blk_k
           | (is_ns & (cfg_i.ns_k_ref ^ cfg_i.blk_k));
    blk_l2 = ~cfg_i.hyp_en;
    blk_l3 = el3_narrow_i & cfg_i.blk_k;
    unique case (lvl_i)
      2'd0:    allow_o = ~blk_l0;
      2'd1:    allow_o = ~blk_l1;
      2'd2:    allow_o = ~blk_l2;
      default: allow_o = ~blk_l3;
    endcase
  end

  a_r9_lvl2_block: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lvl_i == 2'd2 && !cfg_i.hyp_en) |-> !allow_o);
  a_r6_lvl0_block: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lvl_i == 2'd0 && cfg_i.blk_u) |-> !allow_o);
  a_r5_lvl1_block: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lvl_i == 2'd1 && cfg_i.blk_k) |-> !allow_o);
  a_r7_ns_k_mismatch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lvl_i == 2'd1 && sec_i == SEC_NS && (cfg_i.ns_k_ref != cfg_i.blk_k)) |-> !allow_o);
endmodule

// File: rtl/efc_count.sv
module efc_count #(
  parameter int CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             inc_i,
  input  logic             wr_i,
  input  logic [CNT_W-1:0] wr_data_i,
  output logic [CNT_W-1:0] cnt_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (wr_i)    cnt_q <= wr_data_i;   // write wins
    else if (inc_i)   cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;

  a_r10_wr_prio: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> cnt_o == $past(wr_data_i));
  a_r2_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_i && inc_i) |=> cnt_o == $past(cnt_o) + 1'b1);
  a_r2_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_i && !inc_i) |=> $stable(cnt_o));
endmodule

// File: rtl/evt_filt_counter.sv
module evt_filt_counter
  import efc_pkg::*;
#(
  parameter int NUM_EVT = 64
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_EVT-1:0] evt_i,
  input  logic [1:0]         lvl_i,
  input  logic [1:0]         sec_i,
  input  logic               el3_narrow_i,
  input  logic               wr_en_i,
  input  logic               reg_addr_i,
  input  logic [31:0]        wr_data_i,
  output logic [31:0]        rd_data_o,
  output logic [31:0]        cnt_o
);
  localparam int          SEL_W     = (NUM_EVT > 1) ? $clog2(NUM_EVT) : 1;
  localparam logic [16:0] NUM_EVT_L = 17'(NUM_EVT);

  cfg_t cfg;
  logic allow, supported, evt_hit, inc;

  efc_cfg_reg u_cfg (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_i      (wr_en_i & ~reg_addr_i),
    .wr_data_i (wr_data_i),
    .cfg_o     (cfg)
  );

  efc_gate u_gate (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .cfg_i        (cfg),
    .lvl_i        (lvl_i),
    .sec_i        (sec_i),
    .el3_narrow_i (el3_narrow_i),
    .allow_o      (allow)
  );

  assign supported = ({1'b0, cfg.evt_sel} < NUM_EVT_L);
  assign evt_hit   = supported & evt_i[cfg.evt_sel[SEL_W-1:0]];
  assign inc       = evt_hit & allow;

  efc_count #(.CNT_W(32)) u_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .inc_i     (inc),
    .wr_i      (wr_en_i & reg_addr_i),
    .wr_data_i (wr_data_i),
    .cnt_o     (cnt_o)
  );

  assign rd_data_o = reg_addr_i ? cnt_o : 32'(cfg);

  a_r3_unsup_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!supported && !wr_en_i) |=> $stable(cnt_o));
endmodule

// File: tb/evt_filt_counter_test.sv
`timescale 1ns/1ps
module evt_filt_counter_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] evt = '0;
  logic [1:0]  lvl = 2'd0;
  logic [1:0]  sec = 2'd0;
  logic        narrow = 1'b0;
  logic        wr_en = 1'b0;
  logic        addr = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata, cnt;
  int tests = 0, failed = 0;
  bit done = 0;

  localparam logic [31:0] B = 32'h0800_0005;  // level-2 enable, event 5

  always #2 clk = ~clk;

  evt_filt_counter #(.NUM_EVT(64)) uut (
    .clk_i(clk), .rst_ni(rst_n), .evt_i(evt), .lvl_i(lvl), .sec_i(sec),
    .el3_narrow_i(narrow), .wr_en_i(wr_en), .reg_addr_i(addr),
    .wr_data_i(wdata), .rd_data_o(rdata), .cnt_o(cnt));

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      failed++;
      $display("FAIL %s act=%h exp=%h", r, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0; addr = 1'b0;
  endtask

  task automatic rd(input logic a, output logic [31:0] d);
    @(negedge clk); addr = a; #0.5 d = rdata;
  endtask

  task automatic pulse(input logic [63:0] v, input int n);
    @(negedge clk); evt = v;
    repeat (n) @(negedge clk);
    evt = '0;
  endtask

  task automatic flt(input string r, input logic [31:0] ty, input logic [1:0] lv,
                     input logic [1:0] sc, input logic nw, input bit ok);
    wr(1'b0, ty); wr(1'b1, 32'd0);
    lvl = lv; sec = sc; narrow = nw;
    pulse(64'd1 << 5, 5);
    chk(r, cnt, ok ? 32'd5 : 32'd0);
  endtask

  task automatic t_reset;
    logic [31:0] d;
    chk("R1 count", cnt, 32'd0);
    rd(1'b0, d); chk("R1 type", d, 32'd0);
    lvl = 2'd2; pulse(64'd1, 4); chk("R1 lvl2 blocked", cnt, 32'd0);
    lvl = 2'd0; pulse(64'd1, 3); chk("R1 lvl0 counts", cnt, 32'd3);
  endtask

  task automatic t_select;
    wr(1'b0, B); wr(1'b1, 32'd0); lvl = 2'd1; sec = 2'd0;
    pulse(~(64'd1 << 5), 6); chk("R2 other lines", cnt, 32'd0);
    pulse(64'd1 << 5, 7);    chk("R2 selected", cnt, 32'd7);
    wr(1'b1, 32'd0);
    @(negedge clk); evt = 64'd1 << 5;
    @(negedge clk); evt = '0;
    chk("R2 latency", cnt, 32'd1);
  endtask

  task automatic t_unsup;
    logic [31:0] d;
    wr(1'b0, 32'h0800_0100); wr(1'b1, 32'd0); lvl = 2'd0;
    rd(1'b0, d); chk("R3 readback", d, 32'h0800_0100);
    pulse('1, 5); chk("R3 no count", cnt, 32'd0);
    wr(1'b0, 32'h0800_003F); wr(1'b1, 32'd0);
    pulse('1, 4); chk("R3 top supported", cnt, 32'd4);
  endtask

  task automatic t_rsv;
    logic [31:0] d;
    wr(1'b0, 32'hFFFF_FFFF);
    rd(1'b0, d); chk("R4 reserved", d, 32'hF820_FFFF);
  endtask

  task automatic t_filters;
    flt("R6 lvl0 blocked",     B | 32'h4000_0000, 2'd0, 2'd0, 1'b0, 0);
    flt("R6 lvl1 free",        B | 32'h4000_0000, 2'd1, 2'd0, 1'b0, 1);
    flt("R5 lvl1 blocked",     B | 32'h8000_0000, 2'd1, 2'd0, 1'b0, 0);
    flt("R5 lvl3 narrow",      B | 32'h8000_0000, 2'd3, 2'd0, 1'b1, 0);
    flt("R5 lvl3 wide",        B | 32'h8000_0000, 2'd3, 2'd0, 1'b0, 1);
    flt("R5 lvl0 free",        B | 32'h8000_0000, 2'd0, 2'd0, 1'b0, 1);
    flt("R7 ns mismatch",      B | 32'h2000_0000, 2'd1, 2'd1, 1'b0, 0);
    flt("R7 secure",           B | 32'h2000_0000, 2'd1, 2'd0, 1'b0, 1);
    flt("R7 realm",            B | 32'h2000_0000, 2'd1, 2'd2, 1'b0, 1);
    flt("R7 match",            B | 32'hA000_0000, 2'd1, 2'd1, 1'b0, 0);
    flt("R8 ns u mismatch",    B | 32'h1000_0000, 2'd0, 2'd1, 1'b0, 0);
    flt("R8 ns u secure",      B | 32'h1000_0000, 2'd0, 2'd0, 1'b0, 1);
    flt("R8 ns u lvl1",        B | 32'h1000_0000, 2'd1, 2'd1, 1'b0, 1);
    flt("R8 realm mismatch",   B | 32'h0020_0000, 2'd0, 2'd2, 1'b0, 0);
    flt("R8 realm bit in ns",  B | 32'h0020_0000, 2'd0, 2'd1, 1'b0, 1);
    flt("R9 lvl2 blocked",     32'h0000_0005,     2'd2, 2'd1, 1'b0, 0);
    flt("R9 lvl2 enabled",     B,                 2'd2, 2'd1, 1'b0, 1);
  endtask

  task automatic t_prio_wrap;
    wr(1'b0, B); lvl = 2'd0; sec = 2'd0;
    @(negedge clk); evt = 64'd1 << 5; wr_en = 1'b1; addr = 1'b1; wdata = 32'd100;
    @(negedge clk); wr_en = 1'b0; addr = 1'b0;
    chk("R10 write wins", cnt, 32'd100);
    @(negedge clk); evt = '0;
    chk("R10 then counts", cnt, 32'd101);
    wr(1'b1, 32'hFFFF_FFFE);
    pulse(64'd1 << 5, 3); chk("R10 wrap", cnt, 32'd1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset;
    t_select;
    t_unsup;
    t_rsv;
    t_filters;
    t_prio_wrap;
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, failed);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      tests++; failed++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, failed);
      $finish;
    end
  end
endmodule